// File: doc/BRIEF.md
# One-wire bus slot timing generator

This block produces the elementary time slots of a master on a single-wire, open-drain serial bus. The slots are a bus reset with presence detect, a write-0 slot, a write-1 slot and a read slot. A client issues one slot at a time through a small command port: an operation code and a data bit, qualified by a valid strobe. The block then runs the slot on the bus and answers with a one-cycle done pulse and a returned bit.

The bus is modelled as a pull-low enable output (`bus_pull_low`) and a sampled line input (`bus_in`). Releasing the line means dropping the enable. The block never drives the line high, and the line input passes through a two-flop synchronizer before it is used. Every slot phase is a fixed number of microseconds. It is converted to clock cycles by multiplying by `CLKS_PER_US` and by an integer delay coefficient `DELAY_COEF` (default 1).

The controller is a state machine with five named states:
- `ST_IDLE` waits for a request.
- `ST_LOW` holds the line low.
- `ST_WAIT_SAMPLE` has the line released and waits for the sample instant.
- `ST_RECOVER` has the line released and waits out the end of the slot.
- `ST_DONE` marks completion for one cycle.

Its transitions are:
- accept: `ST_IDLE` to `ST_LOW`, taken when `req_valid` is high.
- to_sample: `ST_LOW` to `ST_WAIT_SAMPLE`, taken for reset and read slots.
- to_recover_direct: `ST_LOW` to `ST_RECOVER`, taken for write slots.
- sample_taken: `ST_WAIT_SAMPLE` to `ST_RECOVER`, where the synchronized line is captured.
- finish: `ST_RECOVER` to `ST_DONE`.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `ow_slot_gen`

## Requirements
- R1: After reset, `bus_pull_low`, `busy`, `done` and `rx_bit` are all 0.
- R2: A write with `req_bit`=1 holds the line low for 6 us. It then releases the line for 64 us before `done` is asserted.
- R3: A write with `req_bit`=0 holds the line low for 60 us. It then releases the line for 10 us before `done` is asserted.
- R4: A read holds the line low for 6 us and then releases it. It samples the synchronized line 9 us after the release and waits a further 55 us. `rx_bit` then carries the sampled level: 1 for a released line, 0 for a line held low by a device.
- R5: A bus reset holds the line low for 500 us and samples 70 us after the release. It stays released a further 430 us before `done`. `rx_bit` is 0 when a device holds the line low (present) and 1 when the line is high (absent).
- R6: A touch with `req_bit`=1 behaves exactly as a read. A touch with `req_bit`=0 behaves exactly as a write-0 and returns 0.
- R7: Write slots, and a touch with `req_bit`=0, return `rx_bit`=0 whatever the line level.
- R8: Each phase lasts its microsecond count times `CLKS_PER_US` times `DELAY_COEF` clock cycles. The low phase starts in the cycle after the request is accepted.
- R9: `busy` rises in the cycle after acceptance and stays high through the one-cycle `done` pulse. It is low in the cycle after `done`.
- R10: A request raised while `busy` is high is ignored. The running slot keeps its timing, and no slot follows it.
- R11: `bus_pull_low` is high only during the low phase of a slot. Outside a slot, `rx_bit` holds its value.

Operation codes on `req_op`: 2'b00 bus reset, 2'b01 write (the value comes from `req_bit`), 2'b10 read, 2'b11 touch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Slot request strobe, accepted only when idle |
| req_op | input | 2 | Operation code (reset, write, read, touch) |
| req_bit | input | 1 | Data bit for write and touch |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle pulse at the end of a slot |
| rx_bit | output | 1 | Returned bit of the last slot |
| bus_pull_low | output | 1 | Enable of the open-drain pull-down |
| bus_in | input | 1 | Line level as seen at the pin |

## Verification
The bench runs every operation code with both data bits, against a line that is either released or held low by a simulated device. For each slot it measures the low-phase and released-phase lengths in cycles and compares them with the scaled microsecond counts. A design that swapped the write-0 and write-1 timings, or dropped the coefficient, would show the wrong pulse widths. A design that sampled on the wrong polarity or returned the line level on writes would report the wrong presence or data bit. A request injected in the middle of a slot checks that a design accepting it would neither stretch the running slot nor start a stray slot after `done`.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_TOUCH = 2'b11
    } ow_op_e;

    typedef enum logic [1:0] {
        K_RESET,
        K_WR0,
        K_WR1,
        K_READ
    } ow_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_WAIT_SAMPLE,
        ST_RECOVER,
        ST_DONE
    } ow_state_e;

    function automatic ow_kind_e decode_kind(input ow_op_e op, input logic b);
        ow_kind_e k;
        unique case (op)
            OP_RESET: k = K_RESET;
            OP_WRITE: k = b ? K_WR1 : K_WR0;
            OP_READ:  k = K_READ;
            OP_TOUCH: k = b ? K_READ : K_WR0;
        endcase
        return k;
    endfunction

    // Length of the low phase in microseconds.
    function automatic int low_us(input ow_kind_e k);
        int v;
        unique case (k)
            K_RESET: v = 500;
            K_WR0:   v = 60;
            K_WR1:   v = 6;
            K_READ:  v = 6;
        endcase
        return v;
    endfunction

    // Release-to-sample time in microseconds, 0 when the slot takes no sample.
    function automatic int sample_us(input ow_kind_e k);
        int v;
        unique case (k)
            K_RESET: v = 70;
            K_READ:  v = 9;
            K_WR0:   v = 0;
            K_WR1:   v = 0;
        endcase
        return v;
    endfunction

    // Released tail of the slot in microseconds.
    function automatic int recover_us(input ow_kind_e k);
        int v;
        unique case (k)
            K_RESET: v = 430;
            K_WR0:   v = 10;
            K_WR1:   v = 64;
            K_READ:  v = 55;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ow_timer.sv
module ow_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= len - 1'b1;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ow_slot_gen.sv
module ow_slot_gen
    import ow_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int DELAY_COEF  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       req_bit,
    output logic       busy,
    output logic       done,
    output logic       rx_bit,
    output logic       bus_pull_low,
    input  logic       bus_in
);
    localparam int SCALE   = CLKS_PER_US * DELAY_COEF;
    localparam int MAX_CYC = 1000 * SCALE;
    localparam int TW      = $clog2(MAX_CYC + 1);

    ow_state_e       state_q, state_d;
    ow_kind_e        kind_q, kind_d;
    logic            rx_q;
    logic            line_sync;
    logic            tmr_load, tmr_expired;
    logic [TW-1:0]   tmr_len;

    function automatic logic [TW-1:0] to_cycles(input int us);
        return TW'(us * SCALE);
    endfunction

    ow_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (line_sync)
    );

    ow_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

    // Next-state and phase timer loading.
    always_comb begin
        state_d  = state_q;
        kind_d   = kind_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin                       // accept
                    kind_d   = decode_kind(ow_op_e'(req_op), req_bit);
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_len  = to_cycles(low_us(kind_d));
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (sample_us(kind_q) != 0) begin      // to_sample
                        state_d = ST_WAIT_SAMPLE;
                        tmr_len = to_cycles(sample_us(kind_q));
                    end else begin                         // to_recover_direct
                        state_d = ST_RECOVER;
                        tmr_len = to_cycles(recover_us(kind_q));
                    end
                end
            end
            ST_WAIT_SAMPLE: begin
                if (tmr_expired) begin                     // sample_taken
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_len  = to_cycles(recover_us(kind_q));
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) state_d = ST_DONE;        // finish
            end
            ST_DONE: state_d = ST_IDLE;                    // retire
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, slot kind and returned bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_WR0;
            rx_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            if (state_q == ST_IDLE && req_valid)
                rx_q <= 1'b0;
            else if (state_q == ST_WAIT_SAMPLE && tmr_expired)
                rx_q <= line_sync;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        bus_pull_low = (state_q == ST_LOW);
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_DONE);
        rx_bit       = rx_q;
    end

endmodule

// File: rtl/ow_slot_gen_checker.sv
module ow_slot_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic rx_bit,
    input logic bus_pull_low
);
    // R11: the pull-down is only enabled inside a slot
    p_pull_in_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_pull_low |-> busy);

    // R8: every accepted request starts with a low phase in the next cycle
    p_start_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> bus_pull_low);

    // R9: done is a single-cycle pulse and busy drops after it
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: done only appears while busy
    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10: a running slot cannot be ended early by anything but completion
    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R11: the returned bit holds outside a slot when nothing is requested
    p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> $stable(rx_bit));
endmodule

bind ow_slot_gen ow_slot_gen_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .done         (done),
    .rx_bit       (rx_bit),
    .bus_pull_low (bus_pull_low)
);

// File: tb/tb_ow_slot_gen.sv
module tb_ow_slot_gen;
    localparam int CPU   = 2;
    localparam int COEF  = 3;
    localparam int SCALE = CPU * COEF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic       req_bit = 1'b0;
    logic       busy, done, rx_bit, bus_pull_low;
    logic       slave_low = 1'b0;
    logic       bus_in;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // open-drain line: low if the master or the device pulls it
    assign bus_in = ~(bus_pull_low | slave_low);

    ow_slot_gen #(.CLKS_PER_US(CPU), .DELAY_COEF(COEF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bit(req_bit), .busy(busy), .done(done), .rx_bit(rx_bit),
        .bus_pull_low(bus_pull_low), .bus_in(bus_in)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_low(input int op, input int b);
        if (op == 0) return 500 * SCALE;
        if (op == 2) return 6 * SCALE;
        return (b != 0) ? 6 * SCALE : 60 * SCALE;
    endfunction

    function automatic int exp_rel(input int op, input int b);
        if (op == 0) return (70 + 430) * SCALE;
        if (op == 2) return (9 + 55) * SCALE;
        return (b != 0) ? 64 * SCALE : 10 * SCALE;
    endfunction

    function automatic int exp_rx(input int op, input int b, input int sl);
        if (op == 0 || op == 2 || (op == 3 && b != 0)) return (sl != 0) ? 0 : 1;
        return 0;
    endfunction

    function automatic string tag(input int op, input int b);
        if (op == 0) return "R5 reset";
        if (op == 2) return "R4 read";
        if (op == 3) return (b != 0) ? "R6 touch1" : "R6 touch0";
        return (b != 0) ? "R2 write1" : "R3 write0";
    endfunction

    task automatic run_slot(input int op, input int b, input int sl, input bit inject);
        int lowc = 0;
        int relc = 0;
        int busy_bad = 0;
        @(negedge clk);
        slave_low = (sl != 0);
        req_op    = 2'(op);
        req_bit   = (b != 0);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (bus_pull_low && lowc < 20000) begin
            if (!busy) busy_bad++;
            // R10: a request in the middle of the low phase must be ignored
            req_valid = inject && (lowc == 3);
            req_op    = inject ? 2'b00 : req_op;
            lowc++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!done && relc < 20000) begin
            if (!busy) busy_bad++;
            relc++;
            @(negedge clk);
        end
        check({tag(op, b), " R8 low cycles"}, lowc, exp_low(op, b));
        check({tag(op, b), " R8 released cycles"}, relc, exp_rel(op, b));
        check({tag(op, b), " R7 returned bit"}, int'(rx_bit), exp_rx(op, b, sl));
        check("R9 busy through slot", busy_bad, 0);
        @(negedge clk);
        check("R9 busy low after done", int'(busy), 0);
        if (inject) begin
            for (int i = 0; i < 4; i++) begin
                check("R10 no stray slot", int'(busy | bus_pull_low), 0);
                @(negedge clk);
            end
        end
        check("R11 rx held when idle", int'(rx_bit), exp_rx(op, b, sl));
    endtask

    initial begin
        bit finished = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                // R1: reset state
                check("R1 pull_low", int'(bus_pull_low), 0);
                check("R1 busy", int'(busy), 0);
                check("R1 done", int'(done), 0);
                check("R1 rx_bit", int'(rx_bit), 0);
                rst_n = 1'b1;
                repeat (2) @(negedge clk);
                for (int op = 0; op < 4; op++)
                    for (int b = 0; b < 2; b++)
                        for (int sl = 0; sl < 2; sl++)
                            run_slot(op, b, sl, 1'b0);
                // R10: injection on a long and a short slot
                run_slot(3, 0, 0, 1'b1);
                run_slot(1, 1, 1, 1'b1);
                finished = 1;
            end
            begin
                while (cyc < 150000) @(negedge clk);
            end
        join_any
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule